// File: doc/BRIEF.md
# Dual Mailbox with Pending Flag

This block holds two 32-bit message registers shared between a host processor and a DSP. Each message register is a pair of 16-bit halves. The most significant bit of the high half is a pending flag that tells the receiver new mail has arrived. The outgoing mailbox carries words from the DSP to the host. The incoming mailbox carries words from the host to the DSP.

A message is sent by writing the high half first and the low half second. Writing the low half raises the pending flag. The receiver polls the high half to see the flag, then reads the low half, which lowers the flag.

The DSP reaches the mailboxes through a decoded 8-bit register offset. The host has a select-based port of its own: host writes go to the incoming mailbox, and host reads come from the outgoing mailbox. Both mailboxes are also visible as 32-bit peek outputs. The DSP can raise a one-cycle interrupt request toward the host. Every access completes in one cycle, and read data is combinational from the current register contents. For that reason neither side has a handshake or back-pressure.

Top module: `dual_mailbox`

## Requirements
- R1: After reset, all four halves are zero (`host_peek_out` = 0, `host_peek_in` = 0) and `host_irq` is 0.
- R2: A DSP write at offset 0xFC stores bits 14:0 of the data in the outgoing high half and forces its bit 15 (the pending flag) to 0, one cycle after the access.
- R3: A DSP write at offset 0xFD stores all 16 bits in the outgoing low half and sets bit 15 of the outgoing high half, leaving bits 14:0 of the high half unchanged.
- R4: A host read (`host_sel` = 0 selects the high half, 1 selects the low half) returns the addressed outgoing half. Reading the low half clears the outgoing pending flag. Reading the high half changes nothing.
- R5: A host write to the incoming mailbox follows the R2/R3 rules: the high half stores bits 14:0 with bit 15 forced to 0, and the low half stores 16 bits and sets the incoming pending flag.
- R6: A DSP read at offset 0xFF returns the incoming low half and clears the incoming pending flag. A DSP read at offset 0xFE returns the incoming high half, flag included, with no side effect.
- R7: `host_peek_out` and `host_peek_in` present {high, low} of each mailbox, with the high half in bits 31:16. Peeking never changes state.
- R8: A DSP write at offset 0xFB with data bit 0 set drives `host_irq` high for exactly the next cycle. With bit 0 clear it does not.
- R9: If a DSP write at 0xFD and a host low-half read happen in the same cycle, the DSP access wins: the low half takes the new data and the outgoing flag ends up set.
- R10: If a host low-half write and a DSP read at 0xFF happen in the same cycle, the DSP access wins: the host write is dropped, the incoming low half is unchanged and the incoming flag ends up clear.
- R11: DSP reads at 0xFC and 0xFD return the outgoing halves with no side effect. DSP reads at any other offset return 0. DSP writes to any offset other than 0xFB, 0xFC and 0xFD change no mailbox state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_req | input | 1 | DSP register access this cycle |
| dsp_we | input | 1 | 1 = write, 0 = read |
| dsp_addr | input | 8 | DSP register offset |
| dsp_wdata | input | 16 | DSP write data |
| dsp_rdata | output | 16 | DSP read data for `dsp_addr` (combinational) |
| host_req | input | 1 | Host access this cycle |
| host_we | input | 1 | 1 = write incoming mailbox, 0 = read outgoing mailbox |
| host_sel | input | 1 | 0 = high half, 1 = low half |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected outgoing half (combinational) |
| host_peek_out | output | 32 | Outgoing mailbox {high, low} |
| host_peek_in | output | 32 | Incoming mailbox {high, low} |
| host_irq | output | 1 | One-cycle interrupt request to the host |

## Verification
The hardest situations to reach are the same-cycle collisions of R9 and R10. They need both ports active on the same half in one cycle, while the flag is in the state that makes the loser's effect visible. Directed steps first put the flag in the opposite state, then issue both accesses together. After that, a long random phase drives both ports independently, with offsets biased toward the mapped ones. A behavioural model in the bench tracks the expected register contents and checks read data, peeks and the interrupt every cycle.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int unsigned SLOT_OUT = 0;
  localparam int unsigned SLOT_IN  = 1;
  localparam int unsigned N_SLOTS  = 2;

  typedef struct packed {
    logic wr_hi_out;
    logic wr_lo_out;
    logic rd_lo_in;
    logic wr_irq;
  } dsp_strobe_t;
endpackage

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              rd_lo,
  input  logic [DATA_W-1:0] whi,
  input  logic [DATA_W-1:0] wlo,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q
);
  localparam logic [DATA_W-1:0] FLAG_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] hi_d, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (wr_hi) hi_d = whi & ~FLAG_MASK;
    if (wr_lo) begin
      lo_d = wlo;
      hi_d = hi_d | FLAG_MASK;
    end else if (rd_lo) begin
      hi_d = hi_d & ~FLAG_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  // R3
  lo_write_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (hi_q[DATA_W-1] && lo_q == $past(wlo)));

  // R2
  hi_write_masks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (hi_q[DATA_W-1] == 1'b0 && hi_q[DATA_W-2:0] == $past(whi[DATA_W-2:0])));

  // R4
  lo_read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !wr_lo) |=> !hi_q[DATA_W-1]);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !wr_lo && !rd_lo) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/mbx_dsp_decode.sv
`timescale 1ns/1ps
module mbx_dsp_decode
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_IRQ    = 'hFB,
  parameter logic [ADDR_W-1:0] OFS_OUT_HI = 'hFC,
  parameter logic [ADDR_W-1:0] OFS_OUT_LO = 'hFD,
  parameter logic [ADDR_W-1:0] OFS_IN_HI  = 'hFE,
  parameter logic [ADDR_W-1:0] OFS_IN_LO  = 'hFF
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] out_hi,
  input  logic [DATA_W-1:0] out_lo,
  input  logic [DATA_W-1:0] in_hi,
  input  logic [DATA_W-1:0] in_lo,
  output dsp_strobe_t       stb,
  output logic [DATA_W-1:0] rdata
);
  logic do_wr, do_rd;

  assign do_wr = req && we;
  assign do_rd = req && !we;

  always_comb begin
    stb           = '0;
    stb.wr_irq    = do_wr && (addr == OFS_IRQ);
    stb.wr_hi_out = do_wr && (addr == OFS_OUT_HI);
    stb.wr_lo_out = do_wr && (addr == OFS_OUT_LO);
    stb.rd_lo_in  = do_rd && (addr == OFS_IN_LO);
  end

  always_comb begin
    unique case (addr)
      OFS_OUT_HI: rdata = out_hi;
      OFS_OUT_LO: rdata = out_lo;
      OFS_IN_HI:  rdata = in_hi;
      OFS_IN_LO:  rdata = in_lo;
      default:    rdata = '0;
    endcase
  end

  always_comb begin
    // R11
    strobe_onehot_chk: assert ($onehot0({stb.wr_irq, stb.wr_hi_out, stb.wr_lo_out, stb.rd_lo_in}));
  end
endmodule

// File: rtl/mbx_irq_pulse.sv
`timescale 1ns/1ps
module mbx_irq_pulse #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_irq,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] TRIG_BIT = DATA_W'(1);

  logic fire;
  assign fire = wr_irq && ((wdata & TRIG_BIT) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end

  // R8
  irq_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq && wdata[0]) |=> irq);

  // R8
  irq_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_irq && wdata[0]) |=> !irq);
endmodule

// File: rtl/dual_mailbox.sv
`timescale 1ns/1ps
module dual_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_IRQ    = 'hFB,
  parameter logic [ADDR_W-1:0] OFS_OUT_HI = 'hFC,
  parameter logic [ADDR_W-1:0] OFS_OUT_LO = 'hFD,
  parameter logic [ADDR_W-1:0] OFS_IN_HI  = 'hFE,
  parameter logic [ADDR_W-1:0] OFS_IN_LO  = 'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dsp_req,
  input  logic                dsp_we,
  input  logic [ADDR_W-1:0]   dsp_addr,
  input  logic [DATA_W-1:0]   dsp_wdata,
  output logic [DATA_W-1:0]   dsp_rdata,
  input  logic                host_req,
  input  logic                host_we,
  input  logic                host_sel,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic [2*DATA_W-1:0] host_peek_out,
  output logic [2*DATA_W-1:0] host_peek_in,
  output logic                host_irq
);
  localparam int unsigned FLAG_BIT = DATA_W - 1;

  dsp_strobe_t       stb;
  logic [DATA_W-1:0] hi_q [N_SLOTS];
  logic [DATA_W-1:0] lo_q [N_SLOTS];
  logic              s_wr_hi [N_SLOTS];
  logic              s_wr_lo [N_SLOTS];
  logic              s_rd_lo [N_SLOTS];
  logic [DATA_W-1:0] s_whi [N_SLOTS];
  logic [DATA_W-1:0] s_wlo [N_SLOTS];

  logic h_wr_hi, h_wr_lo, h_rd_lo;

  assign h_wr_hi = host_req &&  host_we && !host_sel;
  assign h_wr_lo = host_req &&  host_we &&  host_sel;
  assign h_rd_lo = host_req && !host_we &&  host_sel;

  mbx_dsp_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .OFS_IRQ(OFS_IRQ), .OFS_OUT_HI(OFS_OUT_HI), .OFS_OUT_LO(OFS_OUT_LO),
    .OFS_IN_HI(OFS_IN_HI), .OFS_IN_LO(OFS_IN_LO)
  ) u_dec (
    .req    (dsp_req),
    .we     (dsp_we),
    .addr   (dsp_addr),
    .out_hi (hi_q[SLOT_OUT]),
    .out_lo (lo_q[SLOT_OUT]),
    .in_hi  (hi_q[SLOT_IN]),
    .in_lo  (lo_q[SLOT_IN]),
    .stb    (stb),
    .rdata  (dsp_rdata)
  );

  // Outgoing: DSP writes, host reads; DSP low write beats host low read.
  assign s_wr_hi[SLOT_OUT] = stb.wr_hi_out;
  assign s_wr_lo[SLOT_OUT] = stb.wr_lo_out;
  assign s_rd_lo[SLOT_OUT] = h_rd_lo && !stb.wr_lo_out;
  assign s_whi[SLOT_OUT]   = dsp_wdata;
  assign s_wlo[SLOT_OUT]   = dsp_wdata;

  // Incoming: host writes, DSP reads; DSP low read beats host low write.
  assign s_wr_hi[SLOT_IN]  = h_wr_hi;
  assign s_wr_lo[SLOT_IN]  = h_wr_lo && !stb.rd_lo_in;
  assign s_rd_lo[SLOT_IN]  = stb.rd_lo_in;
  assign s_whi[SLOT_IN]    = host_wdata;
  assign s_wlo[SLOT_IN]    = host_wdata;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    mbx_slot #(.DATA_W(DATA_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hi (s_wr_hi[g]),
      .wr_lo (s_wr_lo[g]),
      .rd_lo (s_rd_lo[g]),
      .whi   (s_whi[g]),
      .wlo   (s_wlo[g]),
      .hi_q  (hi_q[g]),
      .lo_q  (lo_q[g])
    );
  end

  mbx_irq_pulse #(.DATA_W(DATA_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_irq(stb.wr_irq),
    .wdata (dsp_wdata),
    .irq   (host_irq)
  );

  assign host_rdata    = host_sel ? lo_q[SLOT_OUT] : hi_q[SLOT_OUT];
  assign host_peek_out = {hi_q[SLOT_OUT], lo_q[SLOT_OUT]};
  assign host_peek_in  = {hi_q[SLOT_IN],  lo_q[SLOT_IN]};

  // R9
  out_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req && dsp_we && dsp_addr == OFS_OUT_LO && h_rd_lo)
      |=> (host_peek_out[DATA_W+FLAG_BIT] && host_peek_out[DATA_W-1:0] == $past(dsp_wdata)));

  // R10
  in_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req && !dsp_we && dsp_addr == OFS_IN_LO && h_wr_lo)
      |=> (!host_peek_in[DATA_W+FLAG_BIT] && $stable(host_peek_in[DATA_W-1:0])));

  // R6
  in_hi_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_req && !dsp_we && dsp_addr == OFS_IN_HI && !host_req) |=> $stable(host_peek_in));
endmodule

// File: tb/dual_mailbox_test.sv
`timescale 1ns/1ps
module dual_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dsp_req = 1'b0, dsp_we = 1'b0;
  logic [7:0]  dsp_addr = 8'h00;
  logic [15:0] dsp_wdata = 16'h0;
  logic [15:0] dsp_rdata;
  logic        host_req = 1'b0, host_we = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic [31:0] host_peek_out, host_peek_in;
  logic        host_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int m_ohi = 0, m_olo = 0, m_ihi = 0, m_ilo = 0, m_irq = 0;

  always #4 clk = ~clk;

  dual_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .dsp_req(dsp_req), .dsp_we(dsp_we), .dsp_addr(dsp_addr),
    .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
    .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_peek_out(host_peek_out), .host_peek_in(host_peek_in),
    .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dsp_read_model(input logic [7:0] a);
    case (a)
      8'hFC: return m_ohi;
      8'hFD: return m_olo;
      8'hFE: return m_ihi;
      8'hFF: return m_ilo;
      default: return 0;
    endcase
  endfunction

  task automatic model_update();
    bit dwr = dsp_req && dsp_we;
    bit drd = dsp_req && !dsp_we;
    bit d_fc = dwr && dsp_addr == 8'hFC;
    bit d_fd = dwr && dsp_addr == 8'hFD;
    bit d_ff = drd && dsp_addr == 8'hFF;
    bit h_rlo = host_req && !host_we && host_sel;
    bit h_whi = host_req && host_we && !host_sel;
    bit h_wlo = host_req && host_we && host_sel;
    m_irq = (dwr && dsp_addr == 8'hFB && dsp_wdata[0]) ? 1 : 0;
    if (d_fc) m_ohi = int'(dsp_wdata) & 32'h7FFF;
    if (d_fd) begin
      m_olo = int'(dsp_wdata);
      m_ohi = m_ohi | 32'h8000;
    end else if (h_rlo) m_ohi = m_ohi & 32'h7FFF;
    if (h_whi) m_ihi = int'(host_wdata) & 32'h7FFF;
    if (h_wlo && !d_ff) begin
      m_ilo = int'(host_wdata);
      m_ihi = m_ihi | 32'h8000;
    end
    if (d_ff) m_ihi = m_ihi & 32'h7FFF;
  endtask

  // One cycle: inputs set already at a falling edge; check reads, clock, check state.
  task automatic step(input string tag);
    string rtag;
    #1;
    rtag = (dsp_addr == 8'hFE || dsp_addr == 8'hFF) ? "R6" : "R11";
    chk(rtag, 32'(dsp_rdata), 32'(dsp_read_model(dsp_addr)));
    chk("R4", 32'(host_rdata), host_sel ? 32'(m_olo) : 32'(m_ohi));
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk({tag, "/R7 out"}, host_peek_out, 32'((m_ohi << 16) | m_olo));
    chk({tag, "/R7 in"}, host_peek_in, 32'((m_ihi << 16) | m_ilo));
    chk("R8", 32'(host_irq), 32'(m_irq));
    dsp_req = 0; host_req = 0;
  endtask

  task automatic dsp(input bit we, input logic [7:0] a, input logic [15:0] d);
    dsp_req = 1; dsp_we = we; dsp_addr = a; dsp_wdata = d;
  endtask

  task automatic host(input bit we, input bit sel, input logic [15:0] d);
    host_req = 1; host_we = we; host_sel = sel; host_wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk("R1 out", host_peek_out, 32'h0);
    chk("R1 in", host_peek_in, 32'h0);
    chk("R1 irq", 32'(host_irq), 32'h0);
    step("R1");

    dsp(1, 8'hFC, 16'hFFFF);  step("R2");
    chk("R2 flag", 32'(host_peek_out[31]), 32'h0);
    dsp(1, 8'hFD, 16'h1234);  step("R3");
    chk("R3 flag", 32'(host_peek_out[31]), 32'h1);
    host(0, 0, 16'h0);        step("R4 hi read");
    chk("R4 hi keep", 32'(host_peek_out[31]), 32'h1);
    host(0, 1, 16'h0);        step("R4 lo read");
    chk("R4 clear", 32'(host_peek_out[31]), 32'h0);

    host(1, 0, 16'h8ABC);     step("R5 hi");
    chk("R5 hi", host_peek_in[31:16], 32'h0ABC);
    host(1, 1, 16'h5678);     step("R5 lo");
    chk("R5 flag", 32'(host_peek_in[31]), 32'h1);
    dsp(0, 8'hFE, 16'h0);     step("R6 hi read");
    chk("R6 keep", 32'(host_peek_in[31]), 32'h1);
    dsp(0, 8'hFF, 16'h0);     step("R6 lo read");
    chk("R6 clear", 32'(host_peek_in[31]), 32'h0);

    dsp(1, 8'hFB, 16'h0001);  step("R8 fire");
    chk("R8 pulse", 32'(host_irq), 32'h1);
    step("R8 drop");
    chk("R8 one cycle", 32'(host_irq), 32'h0);
    dsp(1, 8'hFB, 16'hFFFE);  step("R8 bit0 clear");
    chk("R8 no pulse", 32'(host_irq), 32'h0);

    // R9: flag clear, then DSP low write with host low read
    dsp(1, 8'hFD, 16'hBEEF); host(0, 1, 16'h0); step("R9");
    chk("R9 flag", 32'(host_peek_out[31]), 32'h1);
    chk("R9 data", host_peek_out[15:0], 32'hBEEF);

    // R10: flag clear, host low write with DSP low read
    dsp(0, 8'hFF, 16'h0); host(1, 1, 16'hCAFE); step("R10");
    chk("R10 flag", 32'(host_peek_in[31]), 32'h0);
    chk("R10 data", host_peek_in[15:0], 32'h5678);

    // R11: writes to incoming offsets and unmapped offsets ignored
    dsp(1, 8'hFF, 16'hAAAA); step("R11 ff");
    dsp(1, 8'hFE, 16'h5555); step("R11 fe");
    dsp(1, 8'h10, 16'h1111); step("R11 other");
    chk("R11 in", host_peek_in, 32'h0ABC5678);
    dsp(0, 8'h42, 16'h0);    step("R11 unmapped read");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      int pick = $urandom_range(0, 6);
      a = (pick < 5) ? 8'(8'hFB + pick) : 8'($urandom);
      if ($urandom_range(0, 1) == 1) dsp($urandom_range(0, 1) == 1, a, 16'($urandom));
      if ($urandom_range(0, 1) == 1) host($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 16'($urandom));
      step("random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule